// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block is the software-facing queue of an I2C master controller. Software pushes work into a transmit command queue by writing one shared data/command register. Each write becomes either a byte to be sent on the bus or a request to fetch one byte from the target. The choice depends on a single command bit in the written word. Bytes that come back from the bus gather in a receive queue, and software drains them by reading the same register.

Both queues report their fill levels. Each has a programmable threshold that drives an interrupt source: one source fires when the transmit queue runs low, the other when the receive queue holds more than a set amount. A read-only parameter word tells software how deep each queue is. An enable bit gates all activity, and clearing it empties both queues.

The serial bit engine is not part of this block. On the transmit side it takes entries through a valid/ready handshake. On the receive side it offers bytes through a valid/ready handshake, and it reports its own busy state through an input.

Top module: `i2cq_top`

## Requirements
- R1: A write to offset 0x10 with bit 8 clear queues bits 7:0 as a transmit byte. The entry appears at the command port with `cmd_read`=0 and `cmd_byte` equal to that byte. Entries leave the queue in write order, one for each cycle in which `cmd_valid` and `cmd_ready` are both high.
- R2: A write to offset 0x10 with bit 8 set queues a read request. The entry appears with `cmd_read`=1 and `cmd_byte`=0.
- R3: A read of offset 0x10 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes that byte from the receive queue at the clock edge.
- R4: Offset 0x74 returns the transmit queue fill level and offset 0x78 returns the receive queue fill level.
- R5: The receive threshold is at offset 0x38 and the transmit threshold is at offset 0x3C. Both reset to 0. While the block is enabled, `irq_tx_empty` is high when the transmit level is at or below the transmit threshold, and `irq_rx_full` is high when the receive level is above the receive threshold. Both are low while the block is disabled.
- R6: Offset 0xF4 reads as the transmit depth minus one in bits 23:16 and the receive depth minus one in bits 15:8, with all other bits zero.
- R7: Offset 0x6C bit 0 is the enable, and it resets to 0. While the block is disabled, `cmd_valid` and `rx_ready` are low and data writes are discarded. Clearing the enable leaves both levels at zero one cycle later.
- R8: Offset 0x70 bit 0 reads 1 while the block is enabled and either the transmit queue is non-empty or `eng_busy` is high. Otherwise it reads 0.
- R9: A data write while the transmit queue is full is discarded, even if an entry leaves in the same cycle. `irq_tx_over` then pulses high for exactly the next cycle.
- R10: A data read while the receive queue is empty returns 0, and `irq_rx_under` then pulses high for exactly the next cycle.
- R11: `rx_ready` is low while the receive queue is full. A push and a pop on the same queue in the same cycle leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offset 0x10) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| cmd_valid | output | 1 | Transmit entry available to the engine |
| cmd_ready | input | 1 | Engine takes the head entry |
| cmd_read | output | 1 | Head entry is a read request |
| cmd_byte | output | 8 | Head entry byte (0 for a read request) |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue accepts a byte |
| rx_byte | input | 8 | Received byte from the engine |
| eng_busy | input | 1 | Engine is mid-transfer |
| irq_tx_empty | output | 1 | Transmit level at or below threshold |
| irq_rx_full | output | 1 | Receive level above threshold |
| irq_tx_over | output | 1 | One-cycle pulse after a dropped write |
| irq_rx_under | output | 1 | One-cycle pulse after a read of an empty queue |

## Verification
The two queues each have two owners: software on the register side and the engine on the far side. The interesting collisions are a register data write in the same cycle as an engine take on a full transmit queue, and a register data read in the same cycle as an engine push on the receive queue. Directed cases set up these collisions: a full transmit queue with write and take together, and a partly filled receive queue with push and pop together. A seeded random phase then drives all four strobes independently every cycle. A queue model in the bench follows these rules: admission is judged on the level at the start of the cycle, and a concurrent push and pop leave the level unchanged. On every cycle the bench compares the head entry, `rx_ready` and the popped data against that model.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OFS_DATA   = 8'h10;
  localparam logic [7:0] OFS_RX_THR = 8'h38;
  localparam logic [7:0] OFS_TX_THR = 8'h3C;
  localparam logic [7:0] OFS_ENABLE = 8'h6C;
  localparam logic [7:0] OFS_STATUS = 8'h70;
  localparam logic [7:0] OFS_TX_LVL = 8'h74;
  localparam logic [7:0] OFS_RX_LVL = 8'h78;
  localparam logic [7:0] OFS_PARAM  = 8'hF4;

  localparam int READ_CMD_BIT = 8;

  typedef struct packed {
    logic              is_read;
    logic [BYTE_W-1:0] data;
  } tx_entry_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);
  assign level = lvl_q;
  assign rdata = store_q[rptr_q];

  always_comb begin
    do_push = push & ~full & ~flush;
    do_pop  = pop & ~empty & ~flush;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    lvl_d   = lvl_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wptr_q] <= wdata;
  end
endmodule

// File: rtl/i2cq_cfg.sv
module i2cq_cfg
  import i2cq_pkg::*;
#(
  parameter int TLW = 4,
  parameter int RLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [7:0]     addr,
  input  logic [15:0]    wdata,
  output logic           en,
  output logic [TLW-1:0] tx_thr,
  output logic [RLW-1:0] rx_thr
);
  logic           en_q, en_d;
  logic [TLW-1:0] txt_q, txt_d;
  logic [RLW-1:0] rxt_q, rxt_d;

  always_comb begin
    en_d  = en_q;
    txt_d = txt_q;
    rxt_d = rxt_q;
    if (wr) begin
      case (addr)
        OFS_ENABLE: en_d  = wdata[0];
        OFS_TX_THR: txt_d = wdata[TLW-1:0];
        OFS_RX_THR: rxt_d = wdata[RLW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      txt_q <= '0;
      rxt_q <= '0;
    end else begin
      en_q  <= en_d;
      txt_q <= txt_d;
      rxt_q <= rxt_d;
    end
  end

  assign en     = en_q;
  assign tx_thr = txt_q;
  assign rx_thr = rxt_q;
endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags #(
  parameter int TLW = 4,
  parameter int RLW = 4
) (
  input  logic           en,
  input  logic [TLW-1:0] tx_lvl,
  input  logic [TLW-1:0] tx_thr,
  input  logic [RLW-1:0] rx_lvl,
  input  logic [RLW-1:0] rx_thr,
  input  logic           eng_busy,
  output logic           tx_low,
  output logic           rx_high,
  output logic           active
);
  assign tx_low  = en & (tx_lvl <= tx_thr);
  assign rx_high = en & (rx_lvl > rx_thr);
  assign active  = en & ((tx_lvl != '0) | eng_busy);
endmodule

// File: rtl/i2cq_top.sv
module i2cq_top
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_read,
  output logic [7:0]  cmd_byte,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        eng_busy,
  output logic        irq_tx_empty,
  output logic        irq_rx_full,
  output logic        irq_tx_over,
  output logic        irq_rx_under
);
  localparam int TLW = $clog2(TX_DEPTH + 1);
  localparam int RLW = $clog2(RX_DEPTH + 1);
  localparam int EW  = $bits(tx_entry_t);
  localparam logic [7:0] TX_DM1 = 8'(TX_DEPTH - 1);
  localparam logic [7:0] RX_DM1 = 8'(RX_DEPTH - 1);

  logic           en;
  logic [TLW-1:0] tx_thr, tx_lvl;
  logic [RLW-1:0] rx_thr, rx_lvl;
  logic           tx_full, tx_empty, rx_full, rx_empty, status_act;
  logic           data_wr, data_rd, tx_push, tx_pop, rx_push, rx_pop;
  tx_entry_t      new_ent, head_ent;
  logic [7:0]     rx_head;
  logic           over_q, over_d, under_q, under_d;
  logic           unused_wbits;

  assign unused_wbits = ^reg_wdata[31:16];

  i2cq_cfg #(.TLW(TLW), .RLW(RLW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[15:0]), .en(en), .tx_thr(tx_thr), .rx_thr(rx_thr)
  );

  assign data_wr = reg_wr & (reg_addr == OFS_DATA);
  assign data_rd = reg_rd & (reg_addr == OFS_DATA);

  always_comb begin
    new_ent.is_read = reg_wdata[READ_CMD_BIT];
    new_ent.data    = reg_wdata[READ_CMD_BIT] ? '0 : reg_wdata[BYTE_W-1:0];
  end

  assign tx_push   = data_wr & en & ~tx_full;
  assign cmd_valid = en & ~tx_empty;
  assign tx_pop    = cmd_valid & cmd_ready;
  assign cmd_read  = head_ent.is_read;
  assign cmd_byte  = head_ent.data;

  i2cq_fifo #(.W(EW), .DEPTH(TX_DEPTH), .LW(TLW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(~en), .push(tx_push), .wdata(new_ent),
    .pop(tx_pop), .rdata(head_ent), .level(tx_lvl), .full(tx_full),
    .empty(tx_empty)
  );

  assign rx_ready = en & ~rx_full;
  assign rx_push  = rx_valid & rx_ready;
  assign rx_pop   = data_rd & ~rx_empty;

  i2cq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH), .LW(RLW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(~en), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .level(rx_lvl), .full(rx_full),
    .empty(rx_empty)
  );

  i2cq_flags #(.TLW(TLW), .RLW(RLW)) u_flags (
    .en(en), .tx_lvl(tx_lvl), .tx_thr(tx_thr), .rx_lvl(rx_lvl),
    .rx_thr(rx_thr), .eng_busy(eng_busy), .tx_low(irq_tx_empty),
    .rx_high(irq_rx_full), .active(status_act)
  );

  always_comb begin
    over_d  = data_wr & en & tx_full;
    under_d = data_rd & rx_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      over_q  <= over_d;
      under_q <= under_d;
    end
  end

  assign irq_tx_over  = over_q;
  assign irq_rx_under = under_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DATA:   reg_rdata = {24'b0, rx_empty ? 8'h00 : rx_head};
      OFS_RX_THR: reg_rdata = 32'(rx_thr);
      OFS_TX_THR: reg_rdata = 32'(tx_thr);
      OFS_ENABLE: reg_rdata = {31'b0, en};
      OFS_STATUS: reg_rdata = {31'b0, status_act};
      OFS_TX_LVL: reg_rdata = 32'(tx_lvl);
      OFS_RX_LVL: reg_rdata = 32'(rx_lvl);
      OFS_PARAM:  reg_rdata = {8'h00, TX_DM1, RX_DM1, 8'h00};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TLW = 4,
  parameter int RLW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [TLW-1:0] tx_lvl,
  input logic [RLW-1:0] rx_lvl,
  input logic           cmd_valid,
  input logic           rx_ready,
  input logic           irq_tx_over,
  input logic           irq_rx_under
);
  assert_cmd_has_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> tx_lvl != '0);

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!cmd_valid && !rx_ready));

  assert_flush_on_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (tx_lvl == '0 && rx_lvl == '0));

  assert_tx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= TLW'(TX_DEPTH));

  assert_over_only_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_over |-> $past(tx_lvl) == TLW'(TX_DEPTH));

  assert_under_only_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_under |-> $past(rx_lvl) == '0);

  assert_ready_has_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_lvl < RLW'(RX_DEPTH));
endmodule

bind i2cq_top i2cq_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TLW(TLW), .RLW(RLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .cmd_valid(cmd_valid), .rx_ready(rx_ready), .irq_tx_over(irq_tx_over),
  .irq_rx_under(irq_rx_under)
);

// File: tb/i2cq_top_tb.sv
module i2cq_top_tb;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid, cmd_read;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_byte;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_byte = 8'h0;
  logic        eng_busy = 1'b0;
  logic        irq_tx_empty, irq_rx_full, irq_tx_over, irq_rx_under;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] txm[$];
  logic [7:0] rxm[$];

  always #2 clk = ~clk;

  i2cq_top #(.TX_DEPTH(D), .RX_DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_byte(cmd_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .eng_busy(eng_busy), .irq_tx_empty(irq_tx_empty),
    .irq_rx_full(irq_rx_full), .irq_tx_over(irq_tx_over),
    .irq_rx_under(irq_rx_under)
  );

  function automatic logic [8:0] exp_entry(input logic [31:0] w);
    return w[8] ? 9'h100 : {1'b0, w[7:0]};
  endfunction

  function automatic logic [31:0] exp_param(input int td, input int rd);
    return {8'h00, 8'(td - 1), 8'(rd - 1), 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic take(output logic [8:0] e);
    @(negedge clk); e = {cmd_read, cmd_byte}; cmd_ready = 1'b1;
    @(posedge clk); #1 cmd_ready = 1'b0;
  endtask

  task automatic give(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [8:0]  e;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    @(negedge clk);
    chk("R7 cmd_valid reset", cmd_valid, 0);
    chk("R7 rx_ready reset", rx_ready, 0);
    chk("R5 irq_tx_empty off", irq_tx_empty, 0);
    rd(8'h6C, v); chk("R7 enable reset", v, 0);
    rd(8'h3C, v); chk("R5 tx thr reset", v, 0);
    rd(8'h38, v); chk("R5 rx thr reset", v, 0);
    rd(8'h70, v); chk("R8 status reset", v, 0);
    rd(8'hF4, v); chk("R6 param", v, exp_param(D, D));

    // write while disabled is dropped
    wr(8'h10, 32'h55);
    rd(8'h74, v); chk("R7 write while off", v, 0);

    wr(8'h6C, 1);
    @(negedge clk);
    chk("R5 tx_empty at 0", irq_tx_empty, 1);
    rd(8'h70, v); chk("R8 status idle", v, 0);
    eng_busy = 1'b1;
    rd(8'h70, v); chk("R8 status eng_busy", v, 1);
    eng_busy = 1'b0;

    // R1/R2 directed
    wr(8'h10, 32'h0000_00A5);
    wr(8'h10, 32'h0000_01FF);
    rd(8'h74, v); chk("R4 tx level 2", v, 2);
    rd(8'h70, v); chk("R8 status queued", v, 1);
    take(e); chk("R1 byte entry", e, 9'h0A5);
    take(e); chk("R2 read entry", e, 9'h100);
    @(negedge clk); chk("R1 cmd_valid drained", cmd_valid, 0);

    // R9: fill, overflow, write+take together when full
    for (int i = 0; i < D; i++) begin
      v = $urandom & 32'h1FF;
      wr(8'h10, v); txm.push_back(exp_entry(v));
    end
    rd(8'h74, v); chk("R4 tx full level", v, D);
    wr(8'h10, 32'h12);
    @(negedge clk); chk("R9 over pulse", irq_tx_over, 1);
    @(negedge clk); chk("R9 over one cycle", irq_tx_over, 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h34; cmd_ready = 1'b1;
    e = {cmd_read, cmd_byte};
    @(posedge clk); #1 reg_wr = 1'b0; cmd_ready = 1'b0;
    chk("R9 head at collide", e, txm.pop_front());
    @(negedge clk); chk("R9 over on collide", irq_tx_over, 1);
    rd(8'h74, v); chk("R9 full write dropped on collide", v, D - 1);
    while (txm.size() > 0) begin
      take(e); chk("R1 drain order", e, txm.pop_front());
    end

    // R5 tx threshold
    wr(8'h3C, 3);
    for (int i = 1; i <= 5; i++) begin
      wr(8'h10, i);
      @(negedge clk); chk("R5 tx_empty vs thr", irq_tx_empty, (i <= 3) ? 1 : 0);
    end
    wr(8'h6C, 0);
    @(posedge clk);
    rd(8'h74, v); chk("R7 flush tx", v, 0);
    wr(8'h6C, 1);

    // RX path
    wr(8'h38, 2);
    for (int i = 0; i < D; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk); chk("R5 rx_full vs thr", irq_rx_full, (i > 2) ? 1 : 0);
      give(b); rxm.push_back(b);
    end
    @(negedge clk); chk("R11 rx_ready full", rx_ready, 0);
    give(8'hEE);
    rd(8'h78, v); chk("R4 rx level full", v, D);
    rd(8'h10, v); chk("R3 pop head", v, {24'b0, rxm.pop_front()});
    // push and pop same cycle
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 8'h10; rx_valid = 1'b1; rx_byte = 8'h6B;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0; rx_valid = 1'b0;
    chk("R3 pop during push", v, {24'b0, rxm.pop_front()});
    rxm.push_back(8'h6B);
    rd(8'h78, v); chk("R11 level kept", v, D - 1);
    while (rxm.size() > 0) begin
      rd(8'h10, v); chk("R3 order", v, {24'b0, rxm.pop_front()});
    end
    rd(8'h10, v); chk("R10 empty read zero", v, 0);
    @(negedge clk); chk("R10 under pulse", irq_rx_under, 1);
    @(negedge clk); chk("R10 under one cycle", irq_rx_under, 0);

    // random mixed phase
    wr(8'h38, 0);
    for (int n = 0; n < 600; n++) begin
      bit w, r, t, g;
      logic [31:0] wd;
      logic [7:0]  gb;
      int tsz, rsz;
      w = ($urandom % 3) == 0; r = ($urandom % 3) == 0;
      t = ($urandom % 2) == 0; g = ($urandom % 3) == 0;
      wd = $urandom & 32'h1FF; gb = 8'($urandom);
      @(negedge clk);
      tsz = txm.size(); rsz = rxm.size();
      chk("R1 rand valid", cmd_valid, tsz > 0);
      if (tsz > 0) chk("R1 rand head", {cmd_read, cmd_byte}, txm[0]);
      chk("R11 rand ready", rx_ready, rsz < D);
      reg_wr = w; reg_rd = r; reg_addr = 8'h10; reg_wdata = wd;
      cmd_ready = t; rx_valid = g; rx_byte = gb;
      #1;
      if (r) chk("R3 rand data", reg_rdata, (rsz > 0) ? {24'b0, rxm[0]} : 32'h0);
      @(posedge clk); #1;
      reg_wr = 0; reg_rd = 0; cmd_ready = 0; rx_valid = 0;
      if (t && tsz > 0) void'(txm.pop_front());
      if (w && tsz < D) txm.push_back(exp_entry(wd));
      if (r && rsz > 0) void'(rxm.pop_front());
      if (g && rsz < D) rxm.push_back(gb);
    end
    rd(8'h74, v); chk("R4 rand tx level", v, txm.size());
    rd(8'h78, v); chk("R4 rand rx level", v, rxm.size());

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule